// File: doc/BRIEF.md
# Two-Bank Row Activation Timing Guard

This block sits in a memory controller in front of the command encoder for a two-bank SDRAM. In every cycle each bank may present one candidate command (open a row, read, write, or close the row). The guard keeps the row state of each bank and answers per bank in the same cycle. It returns a grant when the command may go out now. It returns a stall when a timing or ordering rule would be broken and the command must be retried. It returns an error when the command can never be legal in the bank's present state.

Each bank has an open-row register, a row-valid flag and a down-counter for the row-to-column delay. That delay is a time parameter in picoseconds. The block turns it into whole clock cycles by rounding the quotient up. The two banks share sensing circuitry, so only one row open is granted per cycle. The lower-numbered bank wins a tie.

Top module: `bank_act_guard`

## Requirements
- R1: After reset every bank is idle: row_open is 0, and with all commands at NOP (code 0) grant, stall and err are 0 and issue_col is zero.
- R2: An activate (code 1) to an idle bank that wins arbitration is granted in the same cycle. From the next cycle that bank shows row_open = 1 and open_row equal to the 11-bit row presented with it.
- R3: A read (code 2) or write (code 3) to an open bank is stalled until TRCD_CYC cycles after its activate. If the activate was granted in cycle t, the first grant comes in cycle t + TRCD_CYC.
- R4: TRCD_CYC is TRCD_PS divided by CLK_PERIOD_PS, rounded up to the next integer. With the defaults of 18000 ps and 4000 ps it is 5 cycles.
- R5: At most one activate is granted per cycle. Among banks requesting an activate to an idle row, the lowest-numbered bank is granted and the others are stalled for that cycle.
- R6: An activate to a bank that already has an open row is stalled, and the bank's open row does not change, until that bank is precharged.
- R7: A read or write to an idle bank is flagged on err. It is neither granted nor stalled, and it leaves the bank idle.
- R8: A precharge (code 4) is always granted. The bank shows row_open = 0 from the next cycle.
- R9: For a granted read or write, issue_col carries the request's 8-bit column. At all other times issue_col for that bank is zero.
- R10: Codes 0, 5, 6 and 7 are no-operations: they give no grant, stall or err and do not change bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | NUM_BANKS x 3 | Candidate command per bank (0 NOP, 1 activate, 2 read, 3 write, 4 precharge) |
| req_row | input | NUM_BANKS x ROW_W | Row address used by activate |
| req_col | input | NUM_BANKS x COL_W | Column address used by read and write |
| grant | output | NUM_BANKS | Command may issue this cycle |
| stall | output | NUM_BANKS | Command must wait and be retried |
| err | output | NUM_BANKS | Read or write aimed at an idle bank |
| row_open | output | NUM_BANKS | Bank holds an open row |
| open_row | output | NUM_BANKS x ROW_W | Row held by each bank |
| issue_col | output | NUM_BANKS x COL_W | Column of a granted read or write, else zero |

## Verification
The in-module assertions assume that a requester holds no state of its own. Each cycle's command is judged only against the guard's registers, so any code value, including a repeated stalled activate or a precharge to an idle bank, is a legal input. The stimulus uses this freedom. Directed sequences cover the tie between the two activates, stalling on an open row, the delay edge one cycle before and at TRCD_CYC, and errors on idle banks. A long run of weighted random commands, including the undefined codes, follows. Inputs change only at the falling edge, away from the edge the assertions sample.

// File: rtl/bank_act_guard_pkg.sv
package bank_act_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;

   localparam int CMD_W = 3;

   // whole cycles covering a time span, rounded up
   function automatic int span_to_cycles(input int span_ps, input int period_ps);
      return (span_ps + period_ps - 1) / period_ps;
   endfunction

endpackage

// File: rtl/act_arbiter.sv
module act_arbiter #(
   parameter int NUM_BANKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] act_ok,
   output logic [NUM_BANKS-1:0] act_win
);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("act_arbiter needs at least two banks");
   end

   // lowest index wins: a bank wins when none below it is eligible
   logic [NUM_BANKS-1:0] below_busy;

   assign below_busy[0] = 1'b0;
   for (genvar b = 1; b < NUM_BANKS; b++) begin : g_chain
      assign below_busy[b] = below_busy[b-1] | act_ok[b-1];
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
      assign act_win[b] = act_ok[b] & ~below_busy[b];
   end

   // R5: never more than one row opened per cycle
   p_single_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_win));

   // R5: an eligible request always yields some winner
   p_act_progress_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok != '0) |-> (act_win != '0));

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
   import bank_act_guard_pkg::*;
#(
   parameter int ROW_W    = 11,
   parameter int COL_W    = 8,
   parameter int TRCD_CYC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic             act_win,
   output logic             act_ok,
   output logic             grant,
   output logic             stall,
   output logic             err,
   output logic             valid,
   output logic [ROW_W-1:0] open_row,
   output logic [COL_W-1:0] issue_col
);

   localparam int CNT_W = (TRCD_CYC < 2) ? 1 : $clog2(TRCD_CYC);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRCD_CYC - 1);

   if (TRCD_CYC < 1) begin : g_bad_trcd
      $error("bank_tracker needs a delay of at least one cycle");
   end

   cmd_e             op;
   logic             valid_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] cnt_q;
   logic             col_ready;
   logic             is_act, is_rdwr, is_pre;
   logic             act_fire, rdwr_fire;

   assign op      = cmd_e'(cmd);
   assign is_act  = (op == CMD_ACT);
   assign is_rdwr = (op == CMD_RD) || (op == CMD_WR);
   assign is_pre  = (op == CMD_PRE);

   assign col_ready = (cnt_q == '0);
   assign act_ok    = is_act & ~valid_q;
   assign act_fire  = act_ok & act_win;
   assign rdwr_fire = is_rdwr & valid_q & col_ready;

   always_comb begin
      grant = 1'b0;
      stall = 1'b0;
      err   = 1'b0;
      unique case (op)
         CMD_ACT: begin
            grant = act_fire;
            stall = ~act_fire;
         end
         CMD_RD, CMD_WR: begin
            grant = rdwr_fire;
            stall = valid_q & ~col_ready;
            err   = ~valid_q;
         end
         CMD_PRE: grant = 1'b1;
         default: ;
      endcase
   end

   assign issue_col = rdwr_fire ? col : '0;
   assign valid     = valid_q;
   assign open_row  = row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         row_q   <= '0;
         cnt_q   <= '0;
      end else begin
         if (act_fire) begin
            valid_q <= 1'b1;
            row_q   <= row;
            cnt_q   <= CNT_LOAD;
         end else begin
            if (is_pre) valid_q <= 1'b0;
            if (!col_ready) cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R6: an open bank never accepts a second activate
   p_open_act_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && valid_q) |-> (stall && !grant));

   // R6: open row held while a repeated activate is refused
   p_open_row_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && valid_q) |=> (valid_q && $stable(row_q)));

   // R7: access to an idle bank is flagged and goes nowhere
   p_idle_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rdwr && !valid_q) |-> (err && !grant && !stall));

   // R8: precharge closes the row from the next cycle
   p_pre_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && grant) |=> !valid_q);

   // R2: a granted activate opens the requested row
   p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && grant) |=> (valid_q && row_q == $past(row)));

   // R9: column leaves only with a granted access
   p_col_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant || !is_rdwr) |-> (issue_col == '0));

   p_resp_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, stall, err}));

   if (TRCD_CYC > 1) begin : g_trcd_chk
      // R3: no access in the cycle after its activate
      p_no_early_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
         act_fire |=> !(is_rdwr && grant));
   end

endmodule

// File: rtl/bank_act_guard.sv
module bank_act_guard
   import bank_act_guard_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int ROW_W         = 11,
   parameter int COL_W         = 8,
   parameter int TRCD_PS       = 18000,
   parameter int CLK_PERIOD_PS = 4000
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_BANKS-1:0][CMD_W-1:0]     req_cmd,
   input  logic [NUM_BANKS-1:0][ROW_W-1:0]     req_row,
   input  logic [NUM_BANKS-1:0][COL_W-1:0]     req_col,
   output logic [NUM_BANKS-1:0]                grant,
   output logic [NUM_BANKS-1:0]                stall,
   output logic [NUM_BANKS-1:0]                err,
   output logic [NUM_BANKS-1:0]                row_open,
   output logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row,
   output logic [NUM_BANKS-1:0][COL_W-1:0]     issue_col
);

   localparam int TRCD_CYC = span_to_cycles(TRCD_PS, CLK_PERIOD_PS);

   if (CLK_PERIOD_PS <= 0 || TRCD_PS <= 0) begin : g_bad_time
      $error("bank_act_guard needs positive time parameters");
   end
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("bank_act_guard needs nonzero address widths");
   end

   logic [NUM_BANKS-1:0] act_ok;
   logic [NUM_BANKS-1:0] act_win;

   act_arbiter #(.NUM_BANKS(NUM_BANKS)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_ok  (act_ok),
      .act_win (act_win)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_tracker #(
         .ROW_W    (ROW_W),
         .COL_W    (COL_W),
         .TRCD_CYC (TRCD_CYC)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd       (req_cmd[b]),
         .row       (req_row[b]),
         .col       (req_col[b]),
         .act_win   (act_win[b]),
         .act_ok    (act_ok[b]),
         .grant     (grant[b]),
         .stall     (stall[b]),
         .err       (err[b]),
         .valid     (row_open[b]),
         .open_row  (open_row[b]),
         .issue_col (issue_col[b])
      );
   end

   // R5: a lower bank's granted activate forces a higher one to stall
   p_tie_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_cmd[0] == CMD_ACT && grant[0] && req_cmd[1] == CMD_ACT) |-> stall[1]);

endmodule

// File: tb/bank_act_guard_test.sv
`timescale 1ns/1ps
module bank_act_guard_test;

   localparam int NB     = 2;
   localparam int RW     = 11;
   localparam int CW     = 8;
   localparam int T_PS   = 18000;
   localparam int P_PS   = 4000;
   localparam int DELAY  = (T_PS + P_PS - 1) / P_PS;   // R4: 5 cycles

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NB-1:0][2:0]      req_cmd;
   logic [NB-1:0][RW-1:0]   req_row;
   logic [NB-1:0][CW-1:0]   req_col;
   logic [NB-1:0]           grant, stall, err, row_open;
   logic [NB-1:0][RW-1:0]   open_row;
   logic [NB-1:0][CW-1:0]   issue_col;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   bit m_open [NB];
   int m_row  [NB];
   int m_age  [NB];

   always #2 clk = ~clk;   // 250 MHz

   bank_act_guard #(
      .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW),
      .TRCD_PS(T_PS), .CLK_PERIOD_PS(P_PS)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .req_cmd(req_cmd), .req_row(req_row), .req_col(req_col),
      .grant(grant), .stall(stall), .err(err),
      .row_open(row_open), .open_row(open_row), .issue_col(issue_col)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, compare, then advance the model
   task automatic step(input int c0, input int r0, input int k0,
                       input int c1, input int r1, input int k1,
                       input string req);
      int  c[NB];
      int  r[NB];
      int  k[NB];
      bit  eg[NB], es[NB], ee[NB];
      bit  taken;
      int  ecol;
      c[0] = c0; c[1] = c1; r[0] = r0; r[1] = r1; k[0] = k0; k[1] = k1;
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         req_cmd[b] = 3'(c[b]);
         req_row[b] = RW'(r[b]);
         req_col[b] = CW'(k[b]);
      end
      #1;
      taken = 1'b0;
      for (int b = 0; b < NB; b++) begin
         eg[b] = 0; es[b] = 0; ee[b] = 0; ecol = 0;
         if (c[b] == 1) begin
            if (!m_open[b] && !taken) begin eg[b] = 1; taken = 1; end
            else es[b] = 1;
         end else if (c[b] == 2 || c[b] == 3) begin
            if (!m_open[b]) ee[b] = 1;
            else if (m_age[b] < DELAY) es[b] = 1;
            else begin eg[b] = 1; ecol = k[b]; end
         end else if (c[b] == 4) begin
            eg[b] = 1;
         end
         check({req, " grant"}, int'(grant[b]), int'(eg[b]));
         check({req, " stall"}, int'(stall[b]), int'(es[b]));
         check({req, " err R7"}, int'(err[b]), int'(ee[b]));
         check({req, " col R9"}, int'(issue_col[b]), ecol);
         check({req, " open R8"}, int'(row_open[b]), int'(m_open[b]));
         if (m_open[b]) check({req, " row R2"}, int'(open_row[b]), m_row[b]);
      end
      for (int b = 0; b < NB; b++) begin
         if (c[b] == 1 && eg[b]) begin
            m_open[b] = 1; m_row[b] = r[b]; m_age[b] = 1;
         end else begin
            if (c[b] == 4) m_open[b] = 0;
            if (m_age[b] < 1000) m_age[b]++;
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      for (int b = 0; b < NB; b++) begin
         m_open[b] = 0; m_row[b] = 0; m_age[b] = 1000;
         req_cmd[b] = '0; req_row[b] = '0; req_col[b] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: idle after reset
      step(0, 0, 0, 0, 0, 0, "R1 reset");
      // R7: access to idle banks
      step(2, 0, 9, 3, 0, 7, "R7 idle access");
      // R10: undefined codes do nothing
      step(5, 3, 1, 7, 4, 2, "R10 undefined");
      step(6, 0, 0, 0, 0, 0, "R10 undefined");
      // R5: tie on activate, bank 0 wins
      step(1, 11'h5a5, 0, 1, 11'h123, 0, "R5 tie");
      // R6: bank 0 again while open; bank 1 now granted
      step(1, 11'h7ff, 0, 1, 11'h123, 0, "R6 open act");
      // R3/R4: bank 0 read stalls until age reaches DELAY
      for (int i = 0; i < 3; i++) step(2, 0, 8'h3c, 0, 0, 0, "R3 early read");
      step(2, 0, 8'h3c, 3, 0, 8'h11, "R4 boundary");
      step(3, 0, 8'hc3, 3, 0, 8'h11, "R3 on time");
      step(0, 0, 0, 2, 0, 8'hff, "R9 column");
      // R8: precharge and reopen
      step(4, 0, 0, 0, 0, 0, "R8 precharge");
      step(2, 0, 1, 1, 9, 0, "R8 closed R6");
      step(1, 11'h400, 0, 4, 0, 0, "R2 reopen");
      step(4, 0, 0, 4, 0, 0, "R8 both");
      step(0, 0, 0, 0, 0, 0, "R1 idle again");

      // weighted random traffic
      for (int n = 0; n < 4000; n++) begin
         int c0, c1;
         c0 = $urandom_range(0, 9); c1 = $urandom_range(0, 9);
         c0 = (c0 < 3) ? 2 + (c0 & 1) : (c0 < 5) ? 1 : (c0 == 5) ? 4 : (c0 == 6) ? 7 : 0;
         c1 = (c1 < 3) ? 2 + (c1 & 1) : (c1 < 5) ? 1 : (c1 == 5) ? 4 : (c1 == 6) ? 5 : 0;
         step(c0, $urandom_range(0, 2047), $urandom_range(0, 255),
              c1, $urandom_range(0, 2047), $urandom_range(0, 255), "R3 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule